// File: doc/BRIEF.md
# Serial Autobaud Detector with Handshake Reply

This block learns the bit rate of an incoming asynchronous serial stream instead of being told it. The receive line idles high. The host opens with the sync character 0x40, framed as 8N1: one start bit, eight data bits sent LSB first, one stop bit and no parity. Sent LSB first, that character starts with a run of seven low bit times: the start bit and then six zero data bits. The block counts the clock cycles in that low run. It turns the count into a divisor for a receiver that oversamples by a fixed factor, and it rounds the divisor to the nearest integer.

Once the divisor is known, the block stores it as a low byte and a high byte. It then transmits a four-byte reply at the learned rate. The reply lets the host confirm the rate and read back the divisor. A clear-to-send output stays low from the moment the sync character starts until the reply has gone out. While it is low, the host must hold off. When the reply is finished, the block raises a done flag and keeps it high until reset. A low run that lasts too long, or one that is too short to yield a divisor, is thrown away and the block waits for the next sync.

Top module: `abd_autobaud`

## Requirements
- R1: While reset is applied and just after it is released, txd=1, cts=1, done=0 and the divisor bytes are 0x00.
- R2: A low run of T clock cycles on rxd, starting from idle, yields the divisor floor((T + 7*OVERSAMPLE/2) / (7*OVERSAMPLE)), which is the rounded value of T/(7*OVERSAMPLE). div_lo carries divisor bits 7:0 and div_hi carries bits 15:8. Both bytes hold the new divisor by the first cycle of the reply's first start bit.
- R3: The reply is four bytes in this order: 0xBF, div_lo, div_hi, 0x00. Each byte is framed as start bit 0, data bits 0 to 7 in that order, then stop bit 1. Every bit lasts exactly divisor*OVERSAMPLE cycles. The first start bit begins no more than divisor+20 cycles after rxd rises.
- R4: cts is 1 in idle and after done. It is 0 from no later than the fourth cycle after rxd falls, until the reply ends.
- R5: In the cycle after the last stop bit ends, done=1 and cts=1. From then until reset, done stays 1 and txd stays 1.
- R6: A low run of TIMEOUT cycles or more returns the block to idle with cts=1. No reply is sent and the divisor is unchanged. A run of TIMEOUT-1 cycles is still accepted.
- R7: A run that rounds to a divisor of 0 (T < 7*OVERSAMPLE/2) is rejected. The block returns to idle with cts=1, sends no reply and leaves the divisor unchanged.
- R8: Activity on rxd after the measured rising edge and before done has no effect on the reply.
- R9: After done, activity on rxd has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idles high |
| txd | output | 1 | Serial transmit line carrying the reply |
| cts | output | 1 | Clear to send; 0 means the host must wait |
| done | output | 1 | High once the reply is complete |
| div_lo | output | 8 | Divisor bits 7:0 |
| div_hi | output | 8 | Divisor bits 15:8 |

## Verification
A wrong low-run count or a wrong rounding step shows up at once on div_lo and div_hi, at the first reply start bit. It also stretches or shrinks every reply bit, so a bench that checks txd every clock flags it within one bit time. A fault in the byte or bit sequencing shows up as a wrong txd level within one bit of where it occurs. A state machine that misses the timeout, the zero-divisor reject or the terminal state shows up on cts or txd within a few cycles: either a stray reply appears or the line fails to return to its idle levels.

// File: rtl/abd_pkg.sv
package abd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_MEAS = 3'd1,
    ST_CALC = 3'd2,
    ST_ACK  = 3'd3,
    ST_DONE = 3'd4
  } abd_state_e;

  // 0x40 sent LSB first gives start + six zeros before the first one
  localparam int SYNC_LOW_BITS = 7;
  localparam int DIV_W         = 16;
  localparam int ACK_BYTES     = 4;
  localparam int FRAME_BITS    = 10;
  localparam logic [7:0] ACK_HEAD = 8'hBF;
  localparam logic [7:0] ACK_TAIL = 8'h00;
endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/abd_measure.sv
module abd_measure #(
  parameter int LEN_W   = 21,
  parameter int TIMEOUT = 1 << 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx,
  input  logic             armed,
  output logic             start_o,
  output logic             done_o,
  output logic             abort_o,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [LEN_W-1:0] LAST = LEN_W'(TIMEOUT - 1);

  logic             prev_q;
  logic             run_q, run_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;

  always_comb begin
    start_o = armed & prev_q & ~rx & ~run_q;
    done_o  = run_q & rx;
    abort_o = run_q & ~rx & (cnt_q == LAST);
    run_d   = run_q;
    cnt_d   = cnt_q;
    if (start_o) begin
      run_d = 1'b1;
      cnt_d = LEN_W'(1);
    end else if (run_q) begin
      if (done_o || abort_o) run_d = 1'b0;
      else                   cnt_d = cnt_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= rx;
      run_q  <= run_d;
      cnt_q  <= cnt_d;
    end
  end

  assign len_o = cnt_q;
endmodule

// File: rtl/abd_divcalc.sv
module abd_divcalc #(
  parameter int LEN_W  = 21,
  parameter int QUO_W  = 16,
  parameter int FACTOR = 112
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN_W-1:0] len,
  output logic             valid_o,
  output logic [QUO_W-1:0] quo_o
);
  localparam int FAC_W = $clog2(FACTOR + 1);
  localparam int REM_W = ((LEN_W > FAC_W) ? LEN_W : FAC_W) + 1;
  localparam logic [REM_W-1:0] FAC  = REM_W'(FACTOR);
  localparam logic [REM_W-1:0] HALF = REM_W'(FACTOR / 2);

  logic             act_q, act_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic [QUO_W-1:0] quo_q, quo_d;
  logic             fits;

  always_comb begin
    fits    = rem_q >= FAC;
    valid_o = act_q & (~fits | (&quo_q));
    act_d   = act_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    if (go) begin
      act_d = 1'b1;
      rem_d = REM_W'(len) + HALF;
      quo_d = '0;
    end else if (act_q) begin
      if (valid_o) begin
        act_d = 1'b0;
      end else begin
        rem_d = rem_q - FAC;
        quo_d = quo_q + QUO_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rem_q <= '0;
      quo_q <= '0;
    end else begin
      act_q <= act_d;
      rem_q <= rem_d;
      quo_q <= quo_d;
    end
  end

  assign quo_o = quo_q;
endmodule

// File: rtl/abd_acktx.sv
module abd_acktx
  import abd_pkg::*;
#(
  parameter int QUO_W      = 16,
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [QUO_W-1:0] quo,
  input  logic [7:0]       lo,
  input  logic [7:0]       hi,
  output logic             txd_o,
  output logic             fin_o
);
  localparam int OVS_W  = $clog2(OVERSAMPLE) + 1;
  localparam int BLEN_W = QUO_W + OVS_W;
  localparam int BYTE_W = $clog2(ACK_BYTES);
  localparam int BIT_W  = $clog2(FRAME_BITS);

  logic [7:0] ack_byte [ACK_BYTES];
  assign ack_byte[0] = ACK_HEAD;
  assign ack_byte[1] = lo;
  assign ack_byte[2] = hi;
  assign ack_byte[3] = ACK_TAIL;

  logic              act_q, act_d;
  logic              txd_q, txd_d;
  logic [BLEN_W-1:0] blen_q, blen_d;
  logic [BLEN_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d, bit_nx;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic [FRAME_BITS-1:0] frame;
  logic              bit_end;

  always_comb begin
    frame   = {1'b1, ack_byte[byte_q], 1'b0};
    bit_nx  = bit_q + BIT_W'(1);
    bit_end = (cnt_q == blen_q - BLEN_W'(1));
    fin_o   = 1'b0;
    act_d   = act_q;
    txd_d   = txd_q;
    blen_d  = blen_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    if (go) begin
      act_d  = 1'b1;
      txd_d  = 1'b0;
      blen_d = BLEN_W'(quo) * BLEN_W'(OVERSAMPLE);
      cnt_d  = '0;
      bit_d  = '0;
      byte_d = '0;
    end else if (act_q) begin
      if (bit_end) begin
        cnt_d = '0;
        if (bit_q == BIT_W'(FRAME_BITS - 1)) begin
          if (byte_q == BYTE_W'(ACK_BYTES - 1)) begin
            act_d = 1'b0;
            txd_d = 1'b1;
            fin_o = 1'b1;
          end else begin
            byte_d = byte_q + BYTE_W'(1);
            bit_d  = '0;
            txd_d  = 1'b0;
          end
        end else begin
          bit_d = bit_nx;
          txd_d = frame[bit_nx];
        end
      end else begin
        cnt_d = cnt_q + BLEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      txd_q  <= 1'b1;
      blen_q <= '0;
      cnt_q  <= '0;
      bit_q  <= '0;
      byte_q <= '0;
    end else begin
      act_q  <= act_d;
      txd_q  <= txd_d;
      blen_q <= blen_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      byte_q <= byte_d;
    end
  end

  assign txd_o = txd_q;
endmodule

// File: rtl/abd_autobaud.sv
module abd_autobaud
  import abd_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int TIMEOUT     = 1 << 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  output logic       txd,
  output logic       cts,
  output logic       done,
  output logic [7:0] div_lo,
  output logic [7:0] div_hi
);
  localparam int FACTOR = OVERSAMPLE * SYNC_LOW_BITS;
  localparam int LEN_W  = $clog2(TIMEOUT + 1);

  logic rst_core_n;
  logic rx_s;

  abd_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_core_n)
  );

  abd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx (
    .clk(clk), .rst_n(rst_core_n), .d(rxd), .q(rx_s)
  );

  abd_state_e       state_q, state_d;
  logic             m_start, m_done, m_abort;
  logic [LEN_W-1:0] m_len;
  logic             calc_go, calc_valid;
  logic [DIV_W-1:0] calc_quo;
  logic             tx_go, tx_fin, tx_txd;
  logic [DIV_W-1:0] div_q;
  logic             div_en;

  abd_measure #(.LEN_W(LEN_W), .TIMEOUT(TIMEOUT)) u_meas (
    .clk(clk), .rst_n(rst_core_n), .rx(rx_s),
    .armed(state_q == ST_IDLE),
    .start_o(m_start), .done_o(m_done), .abort_o(m_abort), .len_o(m_len)
  );

  abd_divcalc #(.LEN_W(LEN_W), .QUO_W(DIV_W), .FACTOR(FACTOR)) u_calc (
    .clk(clk), .rst_n(rst_core_n), .go(calc_go), .len(m_len),
    .valid_o(calc_valid), .quo_o(calc_quo)
  );

  abd_acktx #(.QUO_W(DIV_W), .OVERSAMPLE(OVERSAMPLE)) u_tx (
    .clk(clk), .rst_n(rst_core_n), .go(tx_go), .quo(calc_quo),
    .lo(div_q[7:0]), .hi(div_q[15:8]), .txd_o(tx_txd), .fin_o(tx_fin)
  );

  always_comb begin
    state_d = state_q;
    calc_go = 1'b0;
    tx_go   = 1'b0;
    div_en  = 1'b0;
    case (state_q)
      ST_IDLE: if (m_start) state_d = ST_MEAS;
      ST_MEAS: begin
        if (m_done) begin
          calc_go = 1'b1;
          state_d = ST_CALC;
        end else if (m_abort) begin
          state_d = ST_IDLE;
        end
      end
      ST_CALC: begin
        if (calc_valid) begin
          if (calc_quo == '0) begin
            state_d = ST_IDLE;
          end else begin
            div_en  = 1'b1;
            tx_go   = 1'b1;
            state_d = ST_ACK;
          end
        end
      end
      ST_ACK:  if (tx_fin) state_d = ST_DONE;
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      div_q   <= '0;
    end else begin
      state_q <= state_d;
      if (div_en) div_q <= calc_quo;
    end
  end

  assign txd    = tx_txd;
  assign cts    = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign done   = (state_q == ST_DONE);
  assign div_lo = div_q[7:0];
  assign div_hi = div_q[15:8];
endmodule

// File: rtl/abd_autobaud_chk.sv
module abd_autobaud_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       cts,
  input logic       done,
  input logic [7:0] div_lo,
  input logic [7:0] div_hi
);
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r5_done_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (txd && cts));

  a_r4_tx_only_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    !txd |-> !cts);

  a_r7_done_divisor_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({div_hi, div_lo} != 16'd0));

  a_r9_divisor_frozen_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable({div_hi, div_lo}));

  a_r2_divisor_loads_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({div_hi, div_lo}) |-> !cts);
endmodule

bind abd_autobaud abd_autobaud_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .cts(cts), .done(done),
  .div_lo(div_lo), .div_hi(div_hi)
);

// File: tb/sim_abd_autobaud.sv
module sim_abd_autobaud;
  localparam int OVS = 2;
  localparam int TMO = 6000;

  logic clk, rst_n, rxd;
  logic txd, cts, done;
  logic [7:0] div_lo, div_hi;
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  abd_autobaud #(.OVERSAMPLE(OVS), .TIMEOUT(TMO), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd), .cts(cts),
    .done(done), .div_lo(div_lo), .div_hi(div_hi)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_div(input int t);
    return (t + (7 * OVS) / 2) / (7 * OVS);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    rxd   = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic low_pulse(input int t, input bit hold_check);
    @(negedge clk);
    rxd = 1'b0;
    for (int i = 0; i < t; i++) begin
      @(negedge clk);
      if (hold_check && i == 3) chk(cts == 1'b0, "R4 cts low after sync start", cts, 0);
    end
    rxd = 1'b1;
  endtask

  task automatic expect_idle(input int n, input int dv, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || cts !== 1'b1 || done !== 1'b0 || {div_hi, div_lo} != 16'(dv)) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic expect_ack(input int q, input int wait_max);
    int bl = q * OVS;
    bit seen = 0;
    int hold_bad = 0;
    logic [7:0] bytes [4];
    bytes[0] = 8'hBF;
    bytes[1] = q[7:0];
    bytes[2] = q[15:8];
    bytes[3] = 8'h00;
    for (int i = 0; i < wait_max; i++) begin
      @(negedge clk);
      if (txd == 1'b0) begin
        seen = 1;
        break;
      end
      if (cts !== 1'b0) hold_bad++;
    end
    chk(seen, "R3 reply start bit within bound", seen, 1);
    if (!seen) return;
    chk(hold_bad == 0, "R4 cts low before reply", hold_bad, 0);
    chk({div_hi, div_lo} == 16'(q), "R2 divisor bytes", {div_hi, div_lo}, q);
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 10; k++) begin
        logic expb;
        int bad = 0;
        expb = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : bytes[b][k-1];
        for (int j = 0; j < bl; j++) begin
          if (txd !== expb) bad++;
          if (cts !== 1'b0 || done !== 1'b0) bad++;
          @(negedge clk);
        end
        if (bad != 0)
          $display("FAIL R3 byte %0d bit %0d actual_mismatches=%0d expected=0", b, k, bad);
        checks++;
        if (bad != 0) fails++;
      end
    end
    chk(done === 1'b1 && cts === 1'b1 && txd === 1'b1, "R5 done after last stop bit",
        {done, cts, txd}, 7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rxd   = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1 && cts === 1'b1 && done === 1'b0 && {div_hi, div_lo} == 16'd0,
        "R1 values during reset", {txd, cts, done}, 6);
    do_reset();
    chk(txd === 1'b1 && cts === 1'b1 && done === 1'b0 && {div_hi, div_lo} == 16'd0,
        "R1 values after reset", {txd, cts, done}, 6);

    // R7: run too short for a nonzero divisor
    low_pulse(6, 1'b1);
    repeat (10) @(negedge clk);
    expect_idle(100, 0, "R7 short run rejected");

    // R2 rounding boundary: 7 cycles gives divisor 1
    low_pulse(7, 1'b1);
    chk(expect_div(7) == 1, "R2 model value", expect_div(7), 1);
    expect_ack(expect_div(7), 40);

    // R9: rxd ignored once done
    fork
      low_pulse(21, 1'b0);
      expect_idle_done();
    join

    do_reset();
    low_pulse(20, 1'b1);
    expect_ack(expect_div(20), 40);

    do_reset();
    low_pulse(21, 1'b1);
    expect_ack(expect_div(21), 40);

    // R6: too long a run times out, then a fresh sync still works
    do_reset();
    low_pulse(TMO, 1'b1);
    repeat (5) @(negedge clk);
    expect_idle(50, 0, "R6 timeout returns to idle");
    low_pulse(4200, 1'b1);
    fork
      expect_ack(expect_div(4200), 400);
      begin
        // R8: a stray low pulse during the reply
        repeat (1000) @(negedge clk);
        rxd = 1'b0;
        repeat (30) @(negedge clk);
        rxd = 1'b1;
      end
    join

    // R6 boundary: TIMEOUT-1 cycles accepted
    do_reset();
    low_pulse(TMO - 1, 1'b1);
    expect_ack(expect_div(TMO - 1), 500);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic expect_idle_done();
    int bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done !== 1'b1 || cts !== 1'b1 || txd !== 1'b1 || {div_hi, div_lo} != 16'd1) bad++;
    end
    chk(bad == 0, "R9 rxd ignored after done", bad, 0);
  endtask
endmodule